// File: doc/BRIEF.md
# System Register File with Embedded Status Word

This block keeps the processor's thirty-two 32-bit system registers in one register bank. The status word used by the condition logic is not a separate register: it is entry 5 of the bank. The explicit load instruction, the ALU flag path and the interrupt-mask commands therefore all write the same storage. The branch logic sees the status word on a dedicated output at all times.

The pipeline uses two transfer paths. A load copies a general-purpose register value into the system register that the select field names. The write lands on the next clock edge. A store reads a selected entry combinationally so that the pipeline can write it back to a general-purpose destination.

Two single-cycle commands set and clear the interrupt-disable bit. A flag port lets the ALU rewrite any subset of the five condition bits. Every other bit of the status word is left as it was.

Top module: `sysreg_file`

## Requirements
- R1: After reset every entry reads zero, and the status output is zero.
- R2: A load with select S and value V makes entry S equal V from the next clock edge. All other entries keep their values. This holds for S = 0 and S = 31.
- R3: The store path returns the selected entry combinationally. A store in the cycle after a load to the same entry returns the newly loaded value.
- R4: The status word is entry 5. The status output always equals what the store path returns for select 5, and a load to entry 5 changes the status output.
- R5: The disable command sets bit 5 (interrupt disable) of the status word and changes no other bit.
- R6: The enable command clears bit 5 of the status word and changes no other bit.
- R7: When the disable and enable commands arrive in the same cycle, disable takes priority and bit 5 ends up set.
- R8: A flag update uses a 5-bit mask and a 5-bit value, with bit 0 = Z, bit 1 = S, bit 2 = OV, bit 3 = CY and bit 4 = SAT.
  - Each status bit whose mask bit is set takes the matching value bit.
  - Unmasked flag bits keep their values.
  - Bits 31:6 keep their values, including bit 7 (NMI pending) and bit 6 (exception pending).
- R9: A load to entry 5 in the same cycle as a flag update or an interrupt command wins. The status word becomes exactly the loaded value.
- R10: A load to an entry other than 5 in the same cycle as a flag update or an interrupt command performs both writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en_i | input | 1 | Load a system register this cycle |
| ld_sel_i | input | 5 | Entry written by the load |
| ld_val_i | input | 32 | General-purpose value being loaded |
| st_sel_i | input | 5 | Entry read by the store path |
| st_val_o | output | 32 | Selected entry, combinational |
| irq_dis_i | input | 1 | Set the interrupt-disable bit |
| irq_en_i | input | 1 | Clear the interrupt-disable bit |
| flg_mask_i | input | 5 | Flag bits rewritten by the ALU |
| flg_val_i | input | 5 | New values for the masked flag bits |
| stat_o | output | 32 | Current status word, for branch logic |

## Verification
The assertions check these properties on every cycle:
- the status output matches the store path at select 5;
- a load to entry 5 dominates all other writes;
- masked flag bits take their new values and unmasked ones hold;
- bits 31:6 never move without a load;
- the disable/enable commands act on bit 5 with disable winning.

The bench's scenarios cover the behaviours that involve entries other than the status word:
- reset contents of arbitrary entries;
- loads at the index boundaries 0 and 31;
- read-after-load on the store path;
- a load to another entry coinciding with a flag update.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int FLAG_W   = 5;

    localparam int BIT_Z    = 0;
    localparam int BIT_S    = 1;
    localparam int BIT_OV   = 2;
    localparam int BIT_CY   = 3;
    localparam int BIT_SAT  = 4;
    localparam int BIT_IDIS = 5;
    localparam int BIT_EXCP = 6;
    localparam int BIT_NMIP = 7;

    typedef enum logic [1:0] {
        INTC_NONE    = 2'd0,
        INTC_DISABLE = 2'd1,
        INTC_ENABLE  = 2'd2
    } intc_e;

    typedef struct packed {
        logic [FLAG_W-1:0] mask;
        logic [FLAG_W-1:0] value;
    } flag_upd_t;

endpackage

// File: rtl/sysreg_intc_dec.sv
module sysreg_intc_dec
    import sysreg_pkg::*;
(
    input  logic  dis_i,
    input  logic  en_i,
    output intc_e cmd_o
);

    // Disable has priority when both commands coincide.
    always_comb begin
        if (dis_i) begin
            cmd_o = INTC_DISABLE;
        end else if (en_i) begin
            cmd_o = INTC_ENABLE;
        end else begin
            cmd_o = INTC_NONE;
        end
    end

endmodule

// File: rtl/sysreg_stat_next.sv
module sysreg_stat_next
    import sysreg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_i,
    input  flag_upd_t       upd_i,
    input  intc_e           intc_i,
    output logic [XLEN-1:0] nxt_o,
    output logic            we_o
);

    logic [XLEN-1:0] flag_merged;

    // Per-bit merge of the masked flag values.
    generate
        for (genvar b = 0; b < XLEN; b++) begin : g_bit
            if (b < FLAG_W) begin : g_flag
                assign flag_merged[b] = upd_i.mask[b] ? upd_i.value[b] : cur_i[b];
            end else begin : g_keep
                assign flag_merged[b] = cur_i[b];
            end
        end
    endgenerate

    always_comb begin
        nxt_o = flag_merged;
        unique case (intc_i)
            INTC_DISABLE: nxt_o[BIT_IDIS] = 1'b1;
            INTC_ENABLE:  nxt_o[BIT_IDIS] = 1'b0;
            default:      ;
        endcase
        we_o = (|upd_i.mask) || (intc_i != INTC_NONE);
    end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    parameter int STAT_IDX = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en_i,
    input  logic [IDX_W-1:0]              ld_sel_i,
    input  logic [XLEN-1:0]               ld_val_i,
    input  logic                          stat_we_i,
    input  logic [XLEN-1:0]               stat_val_i,
    output logic [NUM_REGS-1:0][XLEN-1:0] regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] ent;
    } bank_t;

    bank_t               bank_d, bank_q;
    logic [NUM_REGS-1:0] ld_hit;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
            assign ld_hit[g] = ld_en_i && (ld_sel_i == IDX_W'(g));
        end
    endgenerate

    // Explicit load beats the status-word side path on the same entry.
    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ld_hit[i]) begin
                bank_d.ent[i] = ld_val_i;
            end else if ((i == STAT_IDX) && stat_we_i) begin
                bank_d.ent[i] = stat_val_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_o = bank_q.ent;

endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux #(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
    input  logic [IDX_W-1:0]              sel_i,
    output logic [XLEN-1:0]               val_o
);

    always_comb begin
        val_o = regs_i[sel_i];
    end

endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    parameter int STAT_IDX = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en_i,
    input  logic [IDX_W-1:0]  ld_sel_i,
    input  logic [XLEN-1:0]   ld_val_i,
    input  logic [IDX_W-1:0]  st_sel_i,
    output logic [XLEN-1:0]   st_val_o,
    input  logic              irq_dis_i,
    input  logic              irq_en_i,
    input  logic [FLAG_W-1:0] flg_mask_i,
    input  logic [FLAG_W-1:0] flg_val_i,
    output logic [XLEN-1:0]   stat_o
);

    logic [NUM_REGS-1:0][XLEN-1:0] regs;
    intc_e                         intc_cmd;
    flag_upd_t                     flag_upd;
    logic [XLEN-1:0]               stat_nxt;
    logic                          stat_we;

    assign flag_upd.mask  = flg_mask_i;
    assign flag_upd.value = flg_val_i;

    sysreg_intc_dec u_intc (
        .dis_i (irq_dis_i),
        .en_i  (irq_en_i),
        .cmd_o (intc_cmd)
    );

    sysreg_stat_next #(.XLEN(XLEN)) u_stat (
        .cur_i  (regs[STAT_IDX]),
        .upd_i  (flag_upd),
        .intc_i (intc_cmd),
        .nxt_o  (stat_nxt),
        .we_o   (stat_we)
    );

    sysreg_bank #(
        .NUM_REGS (NUM_REGS),
        .XLEN     (XLEN),
        .STAT_IDX (STAT_IDX)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en_i    (ld_en_i),
        .ld_sel_i   (ld_sel_i),
        .ld_val_i   (ld_val_i),
        .stat_we_i  (stat_we),
        .stat_val_i (stat_nxt),
        .regs_o     (regs)
    );

    sysreg_rdmux #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) u_rd (
        .regs_i (regs),
        .sel_i  (st_sel_i),
        .val_o  (st_val_o)
    );

    assign stat_o = regs[STAT_IDX];

endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk
    import sysreg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    parameter int STAT_IDX = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en_i,
    input logic [IDX_W-1:0]  ld_sel_i,
    input logic [XLEN-1:0]   ld_val_i,
    input logic [IDX_W-1:0]  st_sel_i,
    input logic [XLEN-1:0]   st_val_o,
    input logic              irq_dis_i,
    input logic              irq_en_i,
    input logic [FLAG_W-1:0] flg_mask_i,
    input logic [FLAG_W-1:0] flg_val_i,
    input logic [XLEN-1:0]   stat_o
);

    logic ld_stat;
    assign ld_stat = ld_en_i && (ld_sel_i == IDX_W'(STAT_IDX));

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> stat_o == '0);

    a_r4_stat_is_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_sel_i == IDX_W'(STAT_IDX)) |-> st_val_o == stat_o);

    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stat |=> stat_o == $past(ld_val_i));

    a_r5_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_dis_i && !irq_en_i && !ld_stat) |=> stat_o[BIT_IDIS]);

    a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && !irq_dis_i && !ld_stat) |=> !stat_o[BIT_IDIS]);

    a_r7_disable_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && irq_dis_i && !ld_stat) |=> stat_o[BIT_IDIS]);

    a_r8_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stat |=> ((stat_o[FLAG_W-1:0] & $past(flg_mask_i))
                      == ($past(flg_val_i) & $past(flg_mask_i))));

    a_r8_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stat |=> ((stat_o[FLAG_W-1:0] & ~$past(flg_mask_i))
                      == ($past(stat_o[FLAG_W-1:0]) & ~$past(flg_mask_i))));

    a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stat |=> stat_o[XLEN-1:BIT_EXCP] == $past(stat_o[XLEN-1:BIT_EXCP]));

    a_r5_idis_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_stat && !irq_dis_i && !irq_en_i) |=> $stable(stat_o[BIT_IDIS]));

endmodule

bind sysreg_file sysreg_chk #(
    .NUM_REGS (NUM_REGS),
    .XLEN     (XLEN),
    .STAT_IDX (STAT_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en_i    (ld_en_i),
    .ld_sel_i   (ld_sel_i),
    .ld_val_i   (ld_val_i),
    .st_sel_i   (st_sel_i),
    .st_val_o   (st_val_o),
    .irq_dis_i  (irq_dis_i),
    .irq_en_i   (irq_en_i),
    .flg_mask_i (flg_mask_i),
    .flg_val_i  (flg_val_i),
    .stat_o     (stat_o)
);

// File: tb/tb_sysreg_file.sv
module tb_sysreg_file;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [4:0]  ld_sel;
    logic [31:0] ld_val;
    logic [4:0]  st_sel;
    logic [31:0] st_val;
    logic        irq_dis;
    logic        irq_en;
    logic [4:0]  flg_mask;
    logic [4:0]  flg_val;
    logic [31:0] stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sysreg_file dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en_i    (ld_en),
        .ld_sel_i   (ld_sel),
        .ld_val_i   (ld_val),
        .st_sel_i   (st_sel),
        .st_val_o   (st_val),
        .irq_dis_i  (irq_dis),
        .irq_en_i   (irq_en),
        .flg_mask_i (flg_mask),
        .flg_val_i  (flg_val),
        .stat_o     (stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 0; ld_sel = '0; ld_val = '0;
        irq_dis = 0; irq_en = 0; flg_mask = '0; flg_val = '0;
    endtask

    // Apply the current inputs for one edge, then return inputs to idle.
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic read_chk(input string req, input logic [4:0] sel, input logic [31:0] exp);
        st_sel = sel;
        #1;
        chk(req, st_val, exp);
    endtask

    task automatic do_load(input logic [4:0] sel, input logic [31:0] val);
        ld_en = 1; ld_sel = sel; ld_val = val;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 status", stat, 32'h0);
        read_chk("R1 entry0", 5'd0, 32'h0);
        read_chk("R1 entry5", 5'd5, 32'h0);
        read_chk("R1 entry31", 5'd31, 32'h0);
    endtask

    task automatic t_load();
        do_load(5'd3, 32'hA5A5_1234);
        read_chk("R3 read after load", 5'd3, 32'hA5A5_1234);
        read_chk("R2 neighbour untouched", 5'd4, 32'h0);
        chk("R2 status untouched", stat, 32'h0);
        do_load(5'd0, 32'h1111_0000);
        read_chk("R2 entry0", 5'd0, 32'h1111_0000);
        do_load(5'd31, 32'hFFFF_FFFF);
        read_chk("R2 entry31", 5'd31, 32'hFFFF_FFFF);
        read_chk("R2 entry3 kept", 5'd3, 32'hA5A5_1234);
    endtask

    task automatic t_stat_load();
        do_load(5'd5, 32'h0000_00C0);
        chk("R4 status after load", stat, 32'h0000_00C0);
        read_chk("R4 read select 5", 5'd5, 32'h0000_00C0);
    endtask

    task automatic t_irq();
        irq_dis = 1; tick();
        chk("R5 disable", stat, 32'h0000_00E0);
        irq_en = 1; tick();
        chk("R6 enable", stat, 32'h0000_00C0);
        irq_dis = 1; irq_en = 1; tick();
        chk("R7 both commands", stat, 32'h0000_00E0);
        irq_en = 1; tick();
        chk("R6 enable again", stat, 32'h0000_00C0);
    endtask

    task automatic t_flags();
        flg_mask = 5'b00101; flg_val = 5'b11111; tick();
        chk("R8 Z and OV set", stat, 32'h0000_00C5);
        flg_mask = 5'b11010; flg_val = 5'b00010; tick();
        chk("R8 S set CY SAT clear", stat, 32'h0000_00C7);
        flg_mask = 5'b00001; flg_val = 5'b00000; tick();
        chk("R8 Z clear only", stat, 32'h0000_00C6);
        read_chk("R8 via store path", 5'd5, 32'h0000_00C6);
    endtask

    task automatic t_collide();
        ld_en = 1; ld_sel = 5'd5; ld_val = 32'h1234_0000;
        flg_mask = 5'b11111; flg_val = 5'b11111; irq_dis = 1;
        tick();
        chk("R9 load beats flags", stat, 32'h1234_0000);
        ld_en = 1; ld_sel = 5'd9; ld_val = 32'hDEAD_BEEF;
        flg_mask = 5'b00001; flg_val = 5'b00001; irq_dis = 1;
        tick();
        chk("R10 status also updated", stat, 32'h1234_0021);
        read_chk("R10 other entry loaded", 5'd9, 32'hDEAD_BEEF);
        irq_en = 1; tick();
        chk("R6 enable after collide", stat, 32'h1234_0001);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        st_sel = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        @(posedge clk);
        #1;
        t_reset();
        t_load();
        t_stat_load();
        t_irq();
        t_flags();
        t_collide();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule